// File: doc/BRIEF.md
# Triangle Dither Tuning-Word Generator

This block produces the tuning word that drives a digitally controlled master oscillator. The word is expressed as a phase-accumulator increment in units of 100 Hz, so 1 MHz is 10000 and 2 MHz is 20000. A 4-bit frequency code selects the programmed frequency in 100 kHz steps above 1 MHz. Codes above the highest legal step clamp to the 2 MHz setting and raise a flag.

When spread-spectrum dither is selected, the word sweeps in a linear triangle. It starts at the programmed value, falls to a chosen percentage below it and climbs back. It never exceeds the programmed value. The depth code picks the percentage. The rate code picks the triangle period, counted in master ticks. A master tick is a one-cycle enable at the oscillator rate. The sweep advances only on a tick.

Any change on the three setting inputs restarts the triangle at its top. The sweep is run by a three-state machine:
- ST_TOP: the word sits at the programmed value.
- ST_FALL: the offset grows by one step per tick.
- ST_RISE: the offset shrinks by one step per tick.

Transitions:
- A restart sends the machine from any state to ST_TOP.
- From ST_TOP, a tick moves it to ST_FALL if the depth is nonzero.
- From ST_FALL, it moves to ST_RISE when the position reaches half the period.
- From ST_RISE, it moves to ST_TOP when the position returns to zero.

Top module: `dither_tune_gen`

## Requirements
- R1: For a frequency code d from 0 to 10, the tuning word at the top of the sweep is 10000 + 1000*d, and code_bad is 0.
- R2: Frequency codes 11 to 15 act as code 10 (a base of 20000) and drive code_bad to 1.
- R3: Depth codes 0, 1, 2 and 3 give a sweep minimum of base minus 0%, 2%, 4% and 8% of base. For example, at base 20000 these minimums are 20000, 19600, 19200 and 18400.
- R4: The tuning word never exceeds the base, and the base is reached within every period.
- R5: With tick held high, the triangle period is 128, 256, 512 or 1024 cycles for rate codes 0 to 3. The minimum occurs once per period.
- R6: With depth code 0, the tuning word stays constant at the base.
- R7: A change on any setting input returns the word to the new base on the first clock edge after the change. The triangle then restarts from the top.
- R8: While tick is low and no setting changes, the tuning word holds its value.
- R9: After reset, with code 0 applied, the tuning word is 10000 and code_bad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Master tick enable; the sweep advances one step per tick |
| dac_code | input | 4 | Frequency code, 100 kHz steps above 1 MHz |
| depth_sel | input | 2 | Dither depth code (0/2/4/8 %) |
| rate_sel | input | 2 | Dither period code (128 << code ticks) |
| tune_word | output | 16 | Tuning word in 100 Hz units |
| code_bad | output | 1 | Frequency code above the legal range |

## Verification
Assertions check several properties on every cycle:
- the word stays at or below the base;
- the triangle position stays within half a period;
- a setting change zeroes the position;
- the position holds without a tick;
- a zero depth pins the word to the base;
- a bad code always yields the clamped base.

The exact sweep minimum, the period in ticks and the single visit to the bottom per period appear only over whole sweeps. The bench measures these for every depth and rate pair, along with each frequency code's base value.

// File: rtl/dith_pkg.sv
package dith_pkg;
    typedef enum logic [1:0] {
        ST_TOP  = 2'd0,
        ST_FALL = 2'd1,
        ST_RISE = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/dith_cfg.sv
module dith_cfg #(
    parameter int CODE_W     = 4,
    parameter int SEL_W      = 2,
    parameter int TUNE_W     = 16,
    parameter int BASE_UNITS = 10000,
    parameter int STEP_UNITS = 1000,
    parameter int MAX_CODE   = 10,
    parameter int DEPTH_DIV  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] dac_code,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [SEL_W-1:0]  rate_sel,
    output logic              restart,
    output logic [TUNE_W-1:0] base,
    output logic [TUNE_W-1:0] depth,
    output logic [SEL_W-1:0]  rate_q,
    output logic              active,
    output logic              code_bad
);
    localparam int CLAMP_UNITS = BASE_UNITS + STEP_UNITS * MAX_CODE;

    logic [CODE_W-1:0] code_q;
    logic [SEL_W-1:0]  depth_q;
    int unsigned       base_i;
    int unsigned       depth_i;

    assign restart = (dac_code != code_q) || (depth_sel != depth_q) || (rate_sel != rate_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            depth_q <= '0;
            rate_q  <= '0;
        end else if (restart) begin
            code_q  <= dac_code;
            depth_q <= depth_sel;
            rate_q  <= rate_sel;
        end
    end

    always_comb begin
        code_bad = (int'(code_q) > MAX_CODE);
        if (code_bad) base_i = CLAMP_UNITS;
        else          base_i = BASE_UNITS + STEP_UNITS * int'(code_q);
        if (depth_q == '0) depth_i = 0;
        else               depth_i = (base_i << (int'(depth_q) - 1)) / DEPTH_DIV;
        base   = base_i[TUNE_W-1:0];
        depth  = depth_i[TUNE_W-1:0];
        active = (depth_q != '0);
    end

    AST_CLAMP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        code_bad |-> (int'(base) == CLAMP_UNITS)); // R2
endmodule

// File: rtl/dith_sweep_fsm.sv
module dith_sweep_fsm
    import dith_pkg::*;
#(
    parameter int SEL_W          = 2,
    parameter int MIN_HALF_LOG2  = 6,
    parameter int TRI_W          = MIN_HALF_LOG2 + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             active,
    input  logic [SEL_W-1:0] rate_q,
    output logic [TRI_W-1:0] tri_pos,
    output logic             at_top
);
    sweep_state_e     state_q, state_d;
    logic [TRI_W-1:0] pos_q, pos_d;
    logic [TRI_W-1:0] half;

    assign half = TRI_W'(1) << (MIN_HALF_LOG2 + int'(rate_q));

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (restart) begin
            state_d = ST_TOP;
            pos_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_TOP: begin
                    if (active) begin
                        pos_d   = TRI_W'(1);
                        state_d = ST_FALL;
                    end
                end
                ST_FALL: begin
                    pos_d = pos_q + TRI_W'(1);
                    if (pos_q + TRI_W'(1) == half) state_d = ST_RISE;
                end
                ST_RISE: begin
                    pos_d = pos_q - TRI_W'(1);
                    if (pos_q == TRI_W'(1)) state_d = ST_TOP;
                end
                default: begin
                    state_d = ST_TOP;
                    pos_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TOP;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        tri_pos = pos_q;
        at_top  = (state_q == ST_TOP);
    end

    AST_TRI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= half); // R5
    AST_RESTART_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos_q == '0)); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(pos_q)); // R8
endmodule

// File: rtl/dith_scale.sv
module dith_scale #(
    parameter int TUNE_W        = 16,
    parameter int SEL_W         = 2,
    parameter int MIN_HALF_LOG2 = 6,
    parameter int TRI_W         = MIN_HALF_LOG2 + 4
) (
    input  logic [TUNE_W-1:0] base,
    input  logic [TUNE_W-1:0] depth,
    input  logic [SEL_W-1:0]  rate_q,
    input  logic [TRI_W-1:0]  tri_pos,
    output logic [TUNE_W-1:0] tune
);
    localparam int PROD_W = TUNE_W + TRI_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] offset;

    always_comb begin
        prod   = PROD_W'(depth) * PROD_W'(tri_pos);
        offset = prod >> (MIN_HALF_LOG2 + int'(rate_q));
        tune   = base - offset[TUNE_W-1:0];
    end
endmodule

// File: rtl/dither_tune_gen.sv
module dither_tune_gen #(
    parameter int CODE_W        = 4,
    parameter int SEL_W         = 2,
    parameter int TUNE_W        = 16,
    parameter int BASE_UNITS    = 10000,
    parameter int STEP_UNITS    = 1000,
    parameter int MAX_CODE      = 10,
    parameter int DEPTH_DIV     = 50,
    parameter int MIN_HALF_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] dac_code,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [SEL_W-1:0]  rate_sel,
    output logic [TUNE_W-1:0] tune_word,
    output logic              code_bad
);
    localparam int TRI_W = MIN_HALF_LOG2 + (1 << SEL_W);

    logic              restart;
    logic              active;
    logic              at_top;
    logic [TUNE_W-1:0] base;
    logic [TUNE_W-1:0] depth;
    logic [SEL_W-1:0]  rate_q;
    logic [TRI_W-1:0]  tri_pos;

    dith_cfg #(
        .CODE_W(CODE_W), .SEL_W(SEL_W), .TUNE_W(TUNE_W),
        .BASE_UNITS(BASE_UNITS), .STEP_UNITS(STEP_UNITS),
        .MAX_CODE(MAX_CODE), .DEPTH_DIV(DEPTH_DIV)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .depth_sel(depth_sel),
        .rate_sel(rate_sel), .restart(restart), .base(base), .depth(depth),
        .rate_q(rate_q), .active(active), .code_bad(code_bad)
    );

    dith_sweep_fsm #(
        .SEL_W(SEL_W), .MIN_HALF_LOG2(MIN_HALF_LOG2), .TRI_W(TRI_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .active(active), .rate_q(rate_q), .tri_pos(tri_pos), .at_top(at_top)
    );

    dith_scale #(
        .TUNE_W(TUNE_W), .SEL_W(SEL_W), .MIN_HALF_LOG2(MIN_HALF_LOG2), .TRI_W(TRI_W)
    ) i_scale (
        .base(base), .depth(depth), .rate_q(rate_q), .tri_pos(tri_pos),
        .tune(tune_word)
    );

    AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        tune_word <= base); // R4
    AST_TOP_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |-> (tune_word == base)); // R4
    AST_ZERO_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (tune_word == base)); // R6
endmodule

// File: tb/test_dither_tune_gen.sv
module test_dither_tune_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  dac_code = 4'd0;
    logic [1:0]  depth_sel = 2'd0;
    logic [1:0]  rate_sel = 2'd0;
    logic [15:0] tune_word;
    logic        code_bad;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dither_tune_gen i_dither_tune_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dac_code(dac_code),
        .depth_sel(depth_sel), .rate_sel(rate_sel),
        .tune_word(tune_word), .code_bad(code_bad)
    );

    // code -> expected base and flag (R1, R2)
    localparam int VEC_N = 16;
    localparam int EXP_BASE [VEC_N] = '{10000, 11000, 12000, 13000, 14000, 15000,
        16000, 17000, 18000, 19000, 20000, 20000, 20000, 20000, 20000, 20000};
    localparam bit EXP_BAD [VEC_N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
    localparam int PCT [4] = '{0, 2, 4, 8};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset word", int'(tune_word), 10000);
        chk("R9 reset flag", int'(code_bad), 0);
        rst_n = 1'b1;
        settle();

        // table walk over frequency codes, no dither
        for (int v = 0; v < VEC_N; v++) begin
            dac_code = 4'(v);
            settle();
            chk(EXP_BAD[v] ? "R2 clamp word" : "R1 base word", int'(tune_word), EXP_BASE[v]);
            chk(EXP_BAD[v] ? "R2 flag" : "R1 flag", int'(code_bad), int'(EXP_BAD[v]));
        end

        // every depth and rate: min, max, period (R3 R4 R5 R6)
        dac_code = 4'd10;
        for (int d = 0; d < 4; d++) begin
            for (int r = 0; r < 4; r++) begin
                int per, emin, mn, mx, first, second;
                per  = 128 << r;
                emin = 20000 - (20000 * PCT[d]) / 100;
                mn = 70000; mx = 0; first = -1; second = -1;
                tick = 1'b0;
                depth_sel = 2'(d);
                rate_sel  = 2'(r);
                settle();
                tick = 1'b1;
                for (int c = 0; c < 2 * per + 4; c++) begin
                    @(negedge clk);
                    if (int'(tune_word) < mn) mn = int'(tune_word);
                    if (int'(tune_word) > mx) mx = int'(tune_word);
                    if (int'(tune_word) == emin) begin
                        if (first < 0) first = c;
                        else if (second < 0) second = c;
                    end
                end
                chk(d == 0 ? "R6 constant min" : "R3 sweep min", mn, emin);
                chk("R4 sweep max", mx, 20000);
                if (d != 0) chk("R5 period", second - first, per);
            end
        end

        // hold without tick (R8)
        begin
            int held;
            depth_sel = 2'd3; rate_sel = 2'd0; tick = 1'b0;
            settle();
            tick = 1'b1;
            repeat (40) @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
            held = int'(tune_word);
            chk("R8 mid-sweep value below top", int'(held < 20000), 1);
            repeat (20) @(negedge clk);
            chk("R8 hold without tick", int'(tune_word), held);
        end

        // restart on setting change (R7)
        tick = 1'b1;
        repeat (30) @(negedge clk);
        dac_code = 4'd5;
        @(negedge clk);
        chk("R7 restart at new base", int'(tune_word), 15000);
        @(negedge clk);
        chk("R7 first step below base", int'(tune_word < 15000), 1);
        rate_sel = 2'd2;
        @(negedge clk);
        chk("R7 rate change restart", int'(tune_word), 15000);

        // clamped code with dither (R2 R3)
        begin
            int mn;
            mn = 70000;
            dac_code = 4'd13; depth_sel = 2'd3; rate_sel = 2'd0;
            @(negedge clk);
            chk("R2 flag clamp dither", int'(code_bad), 1);
            for (int c = 0; c < 140; c++) begin
                @(negedge clk);
                if (int'(tune_word) < mn) mn = int'(tune_word);
            end
            chk("R2 clamp sweep min", mn, 18400);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule